// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Set/Clear Attribute Writes

This block controls 32 general-purpose pins, split into a lower and an upper bank of 16 pins each. Each pin has eight attributes: output value, input enable, output enable, open-drain, pull-up, pull-down, input invert and output invert. Every attribute register is changed with a set/clear word. The low half of a 32-bit write sets the attribute for the selected pins, and the high half clears it. This lets software change a single pin without first reading the register, and two agents can update different pins without interfering with each other.

The upper bank uses the same register layout as the lower bank, placed at a fixed byte offset of 0x40. Pin 16+n of the chip is pin n of the upper bank. The block drives a per-pin output value and output enable toward the pads, and passes the pull-up and pull-down settings through. Each pad input goes through a two-flop synchronizer and then through the optional input inversion. Reading the value register returns this conditioned input state, not the stored output value.

Top module: `gpio_dual_bank`

## Requirements
- R1: A write with bit n (0..15) set to 1 sets the addressed attribute for pin n of the addressed bank.
- R2: A write with bit n+16 set to 1 clears the addressed attribute for pin n of the addressed bank.
- R3: When the set bit and the clear bit of the same pin are both 1 in one write, the attribute ends up cleared.
- R4: A zero bit leaves its attribute unchanged. Writes to unmapped addresses change nothing. Unmapped means register index 8..15, or byte address bit 7 set.
- R5: Byte address bit 6 selects the bank: 0x00 is the lower bank (pins 0..15) and 0x40 is the upper bank (pins 16..31). The register index is address bits 5:2. Index 0 is the output value, 1 input enable, 2 output enable, 3 open-drain, 4 pull-up, 5 pull-down, 6 input invert, 7 output invert.
- R6: A read at index 1..7 returns that bank's attribute bits in read data bits 15:0, with bits 31:16 at zero. Read data is registered, valid the cycle after `rd_en`, and held while `rd_en` is low. Unmapped reads return zero.
- R7: A read at index 0 returns, per pin of the bank, the pad input after two synchronizer flops, XORed with input invert and ANDed with input enable. The read issued in the same cycle as an input change, and the read in the cycle after it, still return the old value.
- R8: With output enable set and open-drain clear, `pad_oe` is 1 and `pad_o` is the output value XOR output invert.
- R9: With output enable and open-drain both set, `pad_o` is 0 and `pad_oe` is 1 exactly when the output value XOR output invert is 0.
- R10: With output enable clear, `pad_o` and `pad_oe` are 0.
- R11: `pad_pu` and `pad_pd` carry the pull-up and pull-down attributes of every pin.
- R12: After reset, every attribute, every pad output and the read data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data: bits 15:0 set strobes, bits 31:16 clear strobes |
| rdata | output | 32 | Registered read data |
| pad_i | input | 32 | Pad input levels |
| pad_o | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| pad_pu | output | 32 | Pull-up requests |
| pad_pd | output | 32 | Pull-down requests |

## Verification
The bench sweeps every pin of every attribute in both banks. This exposes a design that decodes the bank bit wrongly, which would show up in the other bank's pins, or that swaps set and clear halves, which would leave attributes stuck. It writes words with set and clear bits overlapping, which catches a design where set wins instead of clear. It writes all-zero words and unmapped addresses, which catches a read-modify-write that loses bits or a decoder that aliases index 8 onto index 0. It also reads back-to-back across a pad input change, which catches a synchronizer that is one flop short. In open-drain mode it checks that a high level is never driven.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_ATTR = 8;
  typedef enum logic [2:0] {
    ATTR_VAL  = 3'd0,
    ATTR_IEN  = 3'd1,
    ATTR_OEN  = 3'd2,
    ATTR_ODN  = 3'd3,
    ATTR_PUP  = 3'd4,
    ATTR_PDN  = 3'd5,
    ATTR_IINV = 3'd6,
    ATTR_OINV = 3'd7
  } gpio_attr_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end
  assign rst_no = stage_q[1];
endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic [W-1:0] q_r;

  // clear has priority over set
  always_comb begin
    q_d = q_r;
    if (we) q_d = (q_r | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (we) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end
  assign q = sync_q;
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] oinv,
  input  logic [W-1:0] oen,
  input  logic [W-1:0] odn,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe
);
  logic [W-1:0] level;
  always_comb begin
    level  = val ^ oinv;
    // open-drain: drive low only, release when high
    pad_o  = oen & ~odn & level;
    pad_oe = oen & ~(odn & level);
  end
endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk #(
  parameter int BANK_W = 16,
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [2*BANK_W-1:0] wdata,
  input logic [2*BANK_W-1:0] rdata,
  input logic [PIN_W-1:0]  out_val,
  input logic [PIN_W-1:0]  oen,
  input logic [PIN_W-1:0]  odn,
  input logic [PIN_W-1:0]  pad_o,
  input logic [PIN_W-1:0]  pad_oe
);
  // R9
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oen & odn & pad_o) == '0);
  // R10
  oe_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~oen) == '0);
  // R3
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0) |=>
      ((out_val[BANK_W-1:0] & $past(wdata[BANK_W-1:0] & wdata[2*BANK_W-1:BANK_W])) == '0));
  // R4
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(out_val));
  // R6
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[2*BANK_W-1:BANK_W] == '0);
  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(
  .BANK_W(BANK_W), .PIN_W(PIN_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .rdata(rdata),
  .out_val(attr_q[0]), .oen(attr_q[2]), .odn(attr_q[3]),
  .pad_o(pad_o), .pad_oe(pad_oe)
);

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank #(
  parameter int BANK_W       = 16,
  parameter int NUM_BANKS    = 2,
  parameter int ADDR_W       = 8,
  parameter int BANK_SEL_BIT = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*BANK_W-1:0]   wdata,
  output logic [2*BANK_W-1:0]   rdata,
  input  logic [BANK_W*NUM_BANKS-1:0] pad_i,
  output logic [BANK_W*NUM_BANKS-1:0] pad_o,
  output logic [BANK_W*NUM_BANKS-1:0] pad_oe,
  output logic [BANK_W*NUM_BANKS-1:0] pad_pu,
  output logic [BANK_W*NUM_BANKS-1:0] pad_pd
);
  import gpio_pkg::*;

  localparam int PIN_W   = BANK_W * NUM_BANKS;
  localparam int DATA_W  = 2 * BANK_W;
  localparam int BSEL_W  = $clog2(NUM_BANKS);
  localparam int IDX_W   = BANK_SEL_BIT - 2;
  localparam int TOP_LSB = BANK_SEL_BIT + BSEL_W;

  logic              rst_sync_n;
  logic [PIN_W-1:0]  attr_q [NUM_ATTR];
  logic [PIN_W-1:0]  in_sync;
  logic [PIN_W-1:0]  in_val;
  logic [BSEL_W-1:0] bank_sel;
  logic [IDX_W-1:0]  reg_idx;
  logic              map_ok;
  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  gpio_rst_sync u_rst (.clk(clk), .rst_ni(rst_n), .rst_no(rst_sync_n));

  // address decode
  always_comb begin
    bank_sel = addr[BANK_SEL_BIT +: BSEL_W];
    reg_idx  = addr[2 +: IDX_W];
    map_ok   = ((addr >> TOP_LSB) == '0) && (32'(reg_idx) < NUM_ATTR);
  end

  // attribute storage, one set/clear register per bank and attribute
  for (genvar a = 0; a < NUM_ATTR; a++) begin : g_attr
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic we;
      assign we = wr_en && map_ok && (32'(bank_sel) == b) && (32'(reg_idx) == a);
      gpio_setclr_reg #(.W(BANK_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .we       (we),
        .set_bits (wdata[BANK_W-1:0]),
        .clr_bits (wdata[DATA_W-1:BANK_W]),
        .q        (attr_q[a][b*BANK_W +: BANK_W])
      );
    end
  end

  // input path: synchronize, then invert, then gate
  gpio_in_sync #(.W(PIN_W)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pad_i), .q(in_sync)
  );
  assign in_val = (in_sync ^ attr_q[ATTR_IINV]) & attr_q[ATTR_IEN];

  // output path
  gpio_pad_drive #(.W(PIN_W)) u_drv (
    .val   (attr_q[ATTR_VAL]),
    .oinv  (attr_q[ATTR_OINV]),
    .oen   (attr_q[ATTR_OEN]),
    .odn   (attr_q[ATTR_ODN]),
    .pad_o (pad_o),
    .pad_oe(pad_oe)
  );
  assign pad_pu = attr_q[ATTR_PUP];
  assign pad_pd = attr_q[ATTR_PDN];

  // read mux and registered read data
  always_comb begin
    rd_next = '0;
    if (map_ok) begin
      if (reg_idx == '0)
        rd_next[BANK_W-1:0] = in_val[bank_sel*BANK_W +: BANK_W];
      else
        rd_next[BANK_W-1:0] = attr_q[reg_idx[2:0]][bank_sel*BANK_W +: BANK_W];
    end
    rdata_d = rd_en ? rd_next : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: tb/gpio_dual_bank_test.sv
`timescale 1ns/1ps
module gpio_dual_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata, pad_i;
  logic [31:0] pad_o, pad_oe, pad_pu, pad_pd;

  logic [31:0] model [8];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_dual_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_i(pad_i), .pad_o(pad_o),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input int bank, input int idx);
    return 32'(bank * 64 + idx * 4);
  endfunction

  // write at a negedge; returns at the following negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int idx, bank;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    idx  = int'(a[5:2]);
    bank = int'(a[6]);
    if (a[7] == 1'b0 && idx < 8)
      model[idx][bank*16 +: 16] = (model[idx][bank*16 +: 16] | d[15:0]) & ~d[31:16];
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [31:0] pin_state);
    int idx, bank;
    logic [31:0] inv;
    idx  = int'(a[5:2]);
    bank = int'(a[6]);
    if (a[7] != 1'b0 || idx >= 8) return 32'h0;
    if (idx == 0) begin
      inv = (pin_state ^ model[6]) & model[1];
      return {16'h0, inv[bank*16 +: 16]};
    end
    return {16'h0, model[idx][bank*16 +: 16]};
  endfunction

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] pin_state, input string tag);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    chk(rdata, exp_read(a, pin_state), tag);
  endtask

  task automatic pads_chk(input string tag);
    logic [31:0] lvl;
    lvl = model[0] ^ model[7];
    chk(pad_o,  model[2] & ~model[3] & lvl,   {tag, " R8/R9/R10 pad_o"});
    chk(pad_oe, model[2] & ~(model[3] & lvl), {tag, " R8/R9/R10 pad_oe"});
    chk(pad_pu, model[4], {tag, " R11 pad_pu"});
    chk(pad_pd, model[5], {tag, " R11 pad_pd"});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] old_pins;
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    pad_i = 32'hA5C3_0F96;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state
    pads_chk("R12 reset");
    chk(rdata, 32'h0, "R12 rdata after reset");
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 8; i++) rd_chk(8'(mk_addr(b, i)), pad_i, "R12 reg after reset");

    // R1 R2 R5: single-pin sweep over every attribute of both banks
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 8; i++)
        for (int p = 0; p < 16; p++) begin
          wr(8'(mk_addr(b, i)), 32'h1 << p);
          rd_chk(8'(mk_addr(b, i)), pad_i, "R1 R5 set one pin");
          pads_chk("R1 R5");
          wr(8'(mk_addr(b, i)), 32'h1 << (p + 16));
          rd_chk(8'(mk_addr(b, i)), pad_i, "R2 R5 clear one pin");
        end

    // R3: set and clear together
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 8; i++) begin
        wr(8'(mk_addr(b, i)), 32'h0000_FFFF);
        wr(8'(mk_addr(b, i)), 32'h00FF_0FF0);
        rd_chk(8'(mk_addr(b, i)), pad_i, "R3 clear wins overlap");
        pads_chk("R3");
      end

    // R4: zero write and unmapped writes change nothing
    for (int b = 0; b < 2; b++) begin
      wr(8'(mk_addr(b, 2)), 32'h0);
      rd_chk(8'(mk_addr(b, 2)), pad_i, "R4 zero write");
      for (int i = 8; i < 16; i++) begin
        wr(8'(mk_addr(b, i)), 32'h0000_FFFF);
        rd_chk(8'(mk_addr(b, i)), pad_i, "R4 R6 unmapped read zero");
        for (int k = 0; k < 8; k++) rd_chk(8'(mk_addr(b, k)), pad_i, "R4 unmapped write no effect");
      end
      wr(8'(8'h80 | mk_addr(b, 3)), 32'h0000_FFFF);
      rd_chk(8'(mk_addr(b, 3)), pad_i, "R4 high address bit unmapped");
      pads_chk("R4");
    end

    // R7: input path with enable and invert, and two-flop latency
    wr(8'(mk_addr(0, 1)), 32'h0000_FFFF);
    wr(8'(mk_addr(1, 1)), 32'h0000_F0F0);
    wr(8'(mk_addr(0, 6)), 32'h0000_3C3C);
    wr(8'(mk_addr(1, 6)), 32'h0000_00FF);
    rd_chk(8'(mk_addr(0, 0)), pad_i, "R7 low bank input");
    rd_chk(8'(mk_addr(1, 0)), pad_i, "R7 high bank input");
    old_pins = pad_i;
    pad_i = 32'h5A3C_F069;
    rd_chk(8'(mk_addr(0, 0)), old_pins, "R7 first read after change is old");
    rd_chk(8'(mk_addr(0, 0)), old_pins, "R7 second read after change is old");
    rd_chk(8'(mk_addr(0, 0)), pad_i, "R7 third read shows new");
    rd_chk(8'(mk_addr(1, 0)), pad_i, "R7 high bank new");

    // R6: read data holds while rd_en low
    repeat (3) @(negedge clk);
    chk(rdata, exp_read(8'(mk_addr(1, 0)), pad_i), "R6 rdata held");

    // mixed pseudo-random traffic over all registers and both banks
    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (n % 50 == 49) begin
        pad_i = lfsr ^ 32'h9E37_79B9;
        repeat (3) @(negedge clk);
      end
      wr(lfsr[7:0] & 8'hFC, {lfsr[15:8], lfsr[31:24], lfsr[23:16], lfsr[7:0]});
      rd_chk(lfsr[7:0] & 8'hFC, pad_i, "R1 R2 R3 R6 mixed traffic");
      pads_chk("mixed R8 R9 R10 R11");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule